// File: doc/BRIEF.md
# Programmable Address Window Decoder

This block steers a 32-bit CPU bus address to one of several target ports. It uses eight programmable windows. Each window has a control word and a base word. The control word holds a size mask, a target number, an attribute byte and an enable bit. Windows 0 and 1 also hold a low and a high remap word. These let those two windows translate the address onto a different location in a 64-bit target address space.

A lookup address is compared against every enabled window at once. Windows may overlap, and the lowest-numbered hitting window wins. The registered result gives:
- a hit flag and a miss flag,
- the winning window number,
- its target and attribute,
- the translated 64-bit address.

Software programs the windows through a simple write/read port. To move a window safely, software first clears the window's control word, then writes its base, then rewrites the control word with the enable bit set.

Top module: `addr_window_decoder`

## Requirements
- R1: After reset every register reads as zero, and every lookup reports a miss.
- R2: The configuration port selects a register with `cfg_sel`: 0 = control, 1 = base, 2 = remap low, 3 = remap high. A write with `cfg_we` high stores all 32 bits at the clock edge. `cfg_rdata` presents, one cycle later, the register addressed by `cfg_win`/`cfg_sel` as it stood before that edge's write.
- R3: The control word has four fields: bit 0 is the enable, bits 7:4 the target, bits 15:8 the attribute, and bits 31:16 the size mask. A window hits when it is enabled and the upper address halves of the address and the base agree in every bit where the size mask is zero.
- R4: A size mask of 0x0000 covers exactly 64 KiB, and 0x00FF covers exactly 16 MiB. An address one byte past either range does not hit that window.
- R5: A window whose enable bit is clear never hits. Writing zero to its control word removes it from decoding.
- R6: When several enabled windows hit, the one with the lowest index is reported on `lk_win`, `lk_target` and `lk_attr`.
- R7: On a miss, `lk_miss` is 1 and `lk_hit` is 0. `lk_target`, `lk_attr`, `lk_win` and `lk_xaddr` are then all zero.
- R8: Windows 0 and 1 form the translated address from three parts:
  - upper 32 bits: their remap-high word;
  - bits 31:16: the remap-low upper half where the size mask is zero, and the lookup address where it is one;
  - bits 15:0: the lookup address.
- R9: Windows 2 to 7 output the lookup address with a zero upper word. Their remap registers ignore writes and read as zero.
- R10: A lookup result appears on the outputs one cycle after the address is presented. A configuration write affects only lookups presented after its clock edge, not one presented in the same cycle.
- R11: Address bits 15:0 pass through to `lk_xaddr[15:0]` unchanged on every hit.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_win | input | 3 | Window index for read or write |
| cfg_sel | input | 2 | Register select: 0 control, 1 base, 2 remap low, 3 remap high |
| cfg_wdata | input | 32 | Write data |
| cfg_rdata | output | 32 | Registered read data |
| lk_addr | input | 32 | Lookup address |
| lk_hit | output | 1 | Some enabled window matched |
| lk_miss | output | 1 | No enabled window matched |
| lk_win | output | 3 | Index of the winning window |
| lk_target | output | 4 | Target number of the winning window |
| lk_attr | output | 8 | Attribute of the winning window |
| lk_xaddr | output | 64 | Translated address |

## Verification
Two functions can meet in one cycle: a configuration write and a lookup. The bench disables window 3 and confirms that its range misses. It then presents an address inside that range in the same cycle as the write that re-enables the window.

The first result must still be a miss, because it was decoded from the old contents. The next result, for the same held address, must be a hit with window 3's target. Around this, the bench sweeps a thousand lookup addresses across the whole space, including the window edges and overlaps. Each result is compared with a model evaluated in the bench from the requirements.

// File: rtl/addr_win_pkg.sv
package addr_win_pkg;
  localparam int AW     = 32;
  localparam int HALF_W = 16;
  localparam int TGT_W  = 4;
  localparam int ATTR_W = 8;
  localparam int XA_W   = 2 * AW;

  typedef enum logic [1:0] {
    SEL_CTRL = 2'd0,
    SEL_BASE = 2'd1,
    SEL_RLO  = 2'd2,
    SEL_RHI  = 2'd3
  } cfg_sel_e;

  typedef struct packed {
    logic [HALF_W-1:0] size;
    logic [ATTR_W-1:0] attr;
    logic [TGT_W-1:0]  target;
    logic [2:0]        rsv;
    logic              en;
  } win_ctrl_t;
endpackage

// File: rtl/addr_win_regs.sv
module addr_win_regs
  import addr_win_pkg::*;
#(
  parameter int NUM_WIN   = 8,
  parameter int NUM_REMAP = 2,
  localparam int WIN_W    = $clog2(NUM_WIN)
) (
  input  logic                          clk,
  input  logic                          rst,
  input  logic                          we,
  input  logic [WIN_W-1:0]              win,
  input  logic [1:0]                    sel,
  input  logic [AW-1:0]                 wdata,
  output logic [AW-1:0]                 rdata,
  output logic [NUM_WIN-1:0][AW-1:0]    ctrl_q,
  output logic [NUM_WIN-1:0][AW-1:0]    base_q,
  output logic [NUM_REMAP-1:0][AW-1:0]  rlo_q,
  output logic [NUM_REMAP-1:0][AW-1:0]  rhi_q
);
  cfg_sel_e sel_e;
  assign sel_e = cfg_sel_e'(sel);

  for (genvar w = 0; w < NUM_WIN; w++) begin : g_win
    always_ff @(posedge clk) begin
      if (rst) begin
        ctrl_q[w] <= '0;
        base_q[w] <= '0;
      end else if (we && win == WIN_W'(w)) begin
        if (sel_e == SEL_CTRL) ctrl_q[w] <= wdata;
        if (sel_e == SEL_BASE) base_q[w] <= wdata;
      end
    end
  end

  for (genvar r = 0; r < NUM_REMAP; r++) begin : g_remap
    always_ff @(posedge clk) begin
      if (rst) begin
        rlo_q[r] <= '0;
        rhi_q[r] <= '0;
      end else if (we && win == WIN_W'(r)) begin
        if (sel_e == SEL_RLO) rlo_q[r] <= wdata;
        if (sel_e == SEL_RHI) rhi_q[r] <= wdata;
      end
    end
  end

  logic [AW-1:0] rd_mux;
  always_comb begin
    rd_mux = '0;
    case (sel_e)
      SEL_CTRL: rd_mux = ctrl_q[win];
      SEL_BASE: rd_mux = base_q[win];
      SEL_RLO: for (int r = 0; r < NUM_REMAP; r++)
                 if (win == WIN_W'(r)) rd_mux = rlo_q[r];
      SEL_RHI: for (int r = 0; r < NUM_REMAP; r++)
                 if (win == WIN_W'(r)) rd_mux = rhi_q[r];
      default: rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) rdata <= '0;
    else     rdata <= rd_mux;
  end

  // R2: a control write is visible in the register one cycle later
  assert_ctrl_write_R2: assert property (@(posedge clk) disable iff (rst)
    ($past(we) && $past(sel) == 2'd0 && !$past(rst)) |-> ctrl_q[$past(win)] == $past(wdata));

  // R9: remap registers of windows without remap read as zero
  assert_remap_absent_R9: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(sel[1]) && int'($past(win)) >= NUM_REMAP) |-> rdata == '0);
endmodule

// File: rtl/addr_win_match.sv
module addr_win_match
  import addr_win_pkg::*;
#(
  parameter int NUM_WIN   = 8,
  parameter int NUM_REMAP = 2
) (
  input  logic [AW-1:0]                 addr,
  input  logic [NUM_WIN-1:0][AW-1:0]    ctrl_q,
  input  logic [NUM_WIN-1:0][AW-1:0]    base_q,
  input  logic [NUM_REMAP-1:0][AW-1:0]  rlo_q,
  input  logic [NUM_REMAP-1:0][AW-1:0]  rhi_q,
  output logic [NUM_WIN-1:0]            hit_vec,
  output logic [NUM_WIN-1:0][XA_W-1:0]  xaddr
);
  for (genvar w = 0; w < NUM_WIN; w++) begin : g_cmp
    win_ctrl_t         c;
    logic [HALF_W-1:0] up;
    assign c  = win_ctrl_t'(ctrl_q[w]);
    assign up = addr[AW-1:HALF_W];
    assign hit_vec[w] = c.en &&
      (((up ^ base_q[w][AW-1:HALF_W]) & ~c.size) == '0);

    if (w < NUM_REMAP) begin : g_xl
      assign xaddr[w] = {rhi_q[w],
                         (rlo_q[w][AW-1:HALF_W] & ~c.size) | (up & c.size),
                         addr[HALF_W-1:0]};
    end else begin : g_pass
      assign xaddr[w] = {{AW{1'b0}}, addr};
    end
  end
endmodule

// File: rtl/addr_win_select.sv
module addr_win_select
  import addr_win_pkg::*;
#(
  parameter int NUM_WIN = 8,
  localparam int WIN_W  = $clog2(NUM_WIN)
) (
  input  logic [NUM_WIN-1:0]            hit_vec,
  input  logic [NUM_WIN-1:0][XA_W-1:0]  xaddr,
  input  logic [NUM_WIN-1:0][AW-1:0]    ctrl_q,
  output logic                          hit,
  output logic [WIN_W-1:0]              win_idx,
  output logic [TGT_W-1:0]              target,
  output logic [ATTR_W-1:0]             attr,
  output logic [XA_W-1:0]               xa
);
  win_ctrl_t c;
  always_comb begin
    hit     = 1'b0;
    win_idx = '0;
    target  = '0;
    attr    = '0;
    xa      = '0;
    c       = '0;
    // scan downward so the lowest index is the last to override
    for (int w = NUM_WIN - 1; w >= 0; w--) begin
      if (hit_vec[w]) begin
        c       = win_ctrl_t'(ctrl_q[w]);
        hit     = 1'b1;
        win_idx = WIN_W'(w);
        target  = c.target;
        attr    = c.attr;
        xa      = xaddr[w];
      end
    end
  end
endmodule

// File: rtl/addr_window_decoder.sv
module addr_window_decoder
  import addr_win_pkg::*;
#(
  parameter int NUM_WIN   = 8,
  parameter int NUM_REMAP = 2,
  localparam int WIN_W    = $clog2(NUM_WIN)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cfg_we,
  input  logic [WIN_W-1:0]  cfg_win,
  input  logic [1:0]        cfg_sel,
  input  logic [AW-1:0]     cfg_wdata,
  output logic [AW-1:0]     cfg_rdata,
  input  logic [AW-1:0]     lk_addr,
  output logic              lk_hit,
  output logic              lk_miss,
  output logic [WIN_W-1:0]  lk_win,
  output logic [TGT_W-1:0]  lk_target,
  output logic [ATTR_W-1:0] lk_attr,
  output logic [XA_W-1:0]   lk_xaddr
);
  logic [NUM_WIN-1:0][AW-1:0]   ctrl_q, base_q;
  logic [NUM_REMAP-1:0][AW-1:0] rlo_q, rhi_q;
  logic [NUM_WIN-1:0]           hit_vec;
  logic [NUM_WIN-1:0][XA_W-1:0] xaddr_w;
  logic                         s_hit;
  logic [WIN_W-1:0]             s_win;
  logic [TGT_W-1:0]             s_tgt;
  logic [ATTR_W-1:0]            s_attr;
  logic [XA_W-1:0]              s_xa;

  addr_win_regs #(.NUM_WIN(NUM_WIN), .NUM_REMAP(NUM_REMAP)) u_regs (
    .clk(clk), .rst(rst), .we(cfg_we), .win(cfg_win), .sel(cfg_sel),
    .wdata(cfg_wdata), .rdata(cfg_rdata), .ctrl_q(ctrl_q), .base_q(base_q),
    .rlo_q(rlo_q), .rhi_q(rhi_q));

  addr_win_match #(.NUM_WIN(NUM_WIN), .NUM_REMAP(NUM_REMAP)) u_match (
    .addr(lk_addr), .ctrl_q(ctrl_q), .base_q(base_q), .rlo_q(rlo_q),
    .rhi_q(rhi_q), .hit_vec(hit_vec), .xaddr(xaddr_w));

  addr_win_select #(.NUM_WIN(NUM_WIN)) u_sel (
    .hit_vec(hit_vec), .xaddr(xaddr_w), .ctrl_q(ctrl_q), .hit(s_hit),
    .win_idx(s_win), .target(s_tgt), .attr(s_attr), .xa(s_xa));

  always_ff @(posedge clk) begin
    if (rst) begin
      lk_hit    <= 1'b0;
      lk_miss   <= 1'b1;
      lk_win    <= '0;
      lk_target <= '0;
      lk_attr   <= '0;
      lk_xaddr  <= '0;
    end else begin
      lk_hit    <= s_hit;
      lk_miss   <= !s_hit;
      lk_win    <= s_win;
      lk_target <= s_tgt;
      lk_attr   <= s_attr;
      lk_xaddr  <= s_xa;
    end
  end

  // R1: first result after reset is a miss (all windows disabled)
  assert_reset_miss_R1: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> lk_miss);

  // R7: a miss carries all-zero result fields
  assert_miss_zero_R7: assert property (@(posedge clk) disable iff (rst)
    lk_miss |-> (lk_target == '0 && lk_attr == '0 && lk_win == '0 && lk_xaddr == '0));

  // R11: low half of the address is carried through on a hit
  assert_low_pass_R11: assert property (@(posedge clk) disable iff (rst)
    (lk_hit && !$past(rst)) |-> lk_xaddr[HALF_W-1:0] == $past(lk_addr[HALF_W-1:0]));

  // R6: the reported window hit and no lower window did
  assert_lowest_wins_R6: assert property (@(posedge clk) disable iff (rst)
    (lk_hit && !$past(rst)) |->
      ($past(hit_vec)[lk_win] &&
       (($past(hit_vec) & ((NUM_WIN'(1) << lk_win) - NUM_WIN'(1))) == '0)));
endmodule

// File: tb/tb_addr_window_decoder.sv
module tb_addr_window_decoder;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cfg_we = 1'b0;
  logic [2:0]  cfg_win = '0;
  logic [1:0]  cfg_sel = '0;
  logic [31:0] cfg_wdata = '0;
  logic [31:0] cfg_rdata;
  logic [31:0] lk_addr = '0;
  logic        lk_hit, lk_miss;
  logic [2:0]  lk_win;
  logic [3:0]  lk_target;
  logic [7:0]  lk_attr;
  logic [63:0] lk_xaddr;

  int checks = 0;
  int errors = 0;

  logic [31:0] m_reg [8][4];

  logic        e_hit;
  logic [2:0]  e_win;
  logic [3:0]  e_tgt;
  logic [7:0]  e_attr;
  logic [63:0] e_xa;

  always #5 clk = ~clk;

  addr_window_decoder dut (
    .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_win(cfg_win), .cfg_sel(cfg_sel),
    .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .lk_addr(lk_addr),
    .lk_hit(lk_hit), .lk_miss(lk_miss), .lk_win(lk_win), .lk_target(lk_target),
    .lk_attr(lk_attr), .lk_xaddr(lk_xaddr));

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] mk_ctrl(input logic [15:0] sz, input logic [7:0] at,
                                          input logic [3:0] tg, input logic en);
    return {sz, at, tg, 3'b000, en};
  endfunction

  task automatic model(input logic [31:0] a);
    e_hit = 1'b0; e_win = '0; e_tgt = '0; e_attr = '0; e_xa = '0;
    for (int w = 7; w >= 0; w--) begin
      logic [15:0] sz;
      sz = m_reg[w][0][31:16];
      if (m_reg[w][0][0] && ((a[31:16] & ~sz) == (m_reg[w][1][31:16] & ~sz))) begin
        e_hit = 1'b1; e_win = 3'(w);
        e_tgt = m_reg[w][0][7:4]; e_attr = m_reg[w][0][15:8];
        if (w < 2) e_xa = {m_reg[w][3], (m_reg[w][2][31:16] & ~sz) | (a[31:16] & sz), a[15:0]};
        else       e_xa = {32'h0, a};
      end
    end
  endtask

  task automatic cmp_lookup(input string req);
    chk({req, " hit"}, 64'(lk_hit), 64'(e_hit));
    chk({req, " miss"}, 64'(lk_miss), 64'(!e_hit));
    chk({req, " win"}, 64'(lk_win), 64'(e_win));
    chk({req, " target"}, 64'(lk_target), 64'(e_tgt));
    chk({req, " attr"}, 64'(lk_attr), 64'(e_attr));
    chk({req, " xaddr"}, lk_xaddr, e_xa);
  endtask

  task automatic lookup(input logic [31:0] a, input string req);
    @(negedge clk);
    lk_addr = a;
    @(negedge clk);
    model(a);
    cmp_lookup(req);
  endtask

  task automatic wr(input int w, input int s, input logic [31:0] d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_win = 3'(w); cfg_sel = 2'(s); cfg_wdata = d;
    @(negedge clk);
    cfg_we = 1'b0;
    if (s < 2 || w < 2) m_reg[w][s] = d;   // R9: remap writes to windows 2..7 are dropped
  endtask

  task automatic rd(input int w, input int s, input string req);
    @(negedge clk);
    cfg_win = 3'(w); cfg_sel = 2'(s);
    @(negedge clk);
    chk(req, 64'(cfg_rdata), 64'(m_reg[w][s]));
  endtask

  task automatic prog(input int w, input logic [15:0] base_up, input logic [15:0] sz,
                      input logic [7:0] at, input logic [3:0] tg);
    wr(w, 0, 32'h0);
    wr(w, 1, {base_up, 16'h0});
    wr(w, 0, mk_ctrl(sz, at, tg, 1'b1));
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=timeout expected=completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    for (int w = 0; w < 8; w++)
      for (int s = 0; s < 4; s++) m_reg[w][s] = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;

    // R1: reset state
    for (int w = 0; w < 8; w++)
      for (int s = 0; s < 4; s++) rd(w, s, "R1 reset readback");
    lookup(32'h0000_0000, "R1 reset lookup");
    lookup(32'hFFFF_FFFF, "R1 reset lookup");

    // program windows
    wr(0, 2, 32'h8000_0000); wr(0, 3, 32'h0000_0001);
    wr(1, 2, 32'h3000_0000); wr(1, 3, 32'h0000_0002);
    prog(0, 16'h1000, 16'h00FF, 8'h11, 4'd1);
    prog(1, 16'h2000, 16'h0000, 8'h22, 4'd2);
    prog(2, 16'h4000, 16'h0FFF, 8'h33, 4'd3);
    prog(3, 16'h5000, 16'h000F, 8'h44, 4'd4);
    prog(4, 16'h4100, 16'h00FF, 8'h55, 4'd5);
    prog(5, 16'h6000, 16'h03FF, 8'h66, 4'd6);
    prog(6, 16'hF000, 16'h0FFF, 8'h77, 4'd7);
    prog(7, 16'hFF00, 16'h00FF, 8'h88, 4'd8);

    // R2: readback of all registers
    for (int w = 0; w < 8; w++)
      for (int s = 0; s < 4; s++) rd(w, s, "R2 readback");

    // R4: size boundaries
    lookup(32'h1000_0000, "R4 16MiB first");
    lookup(32'h10FF_FFFF, "R4 16MiB last");
    lookup(32'h1100_0000, "R4 16MiB past");
    lookup(32'h0FFF_FFFF, "R4 16MiB before");
    lookup(32'h2000_0000, "R4 64KiB first");
    lookup(32'h2000_FFFF, "R4 64KiB last");
    lookup(32'h2001_0000, "R4 64KiB past");

    // R8: remap translation in windows 0 and 1
    lookup(32'h1023_4567, "R8 remap w0");
    lookup(32'h2000_ABCD, "R8 remap w1");
    // R6: overlap priority
    lookup(32'h4180_0000, "R6 overlap w2 over w4");
    lookup(32'hFF12_3456, "R6 overlap w6 over w7");
    // R9: pass-through windows
    lookup(32'h6123_4567, "R9 passthru w5");

    // R3/R11: broad sweep over the address space
    for (int k = 0; k < 1024; k++)
      lookup({16'(k * 64 + (k % 7)), 16'(k * 37)}, "R3 sweep");

    // R9: remap write to window 5 ignored
    wr(5, 2, 32'hDEAD_0000);
    wr(5, 3, 32'hBEEF_0000);
    rd(5, 2, "R9 remap lo absent");
    rd(5, 3, "R9 remap hi absent");
    lookup(32'h6000_1111, "R9 after ignored remap");

    // R5: disabling window 6 uncovers window 7
    wr(6, 0, 32'h0);
    lookup(32'hFF12_3456, "R5 w6 disabled, w7 wins");
    lookup(32'hF012_3456, "R5 w6 disabled miss");

    // R10: write and lookup in the same cycle
    wr(3, 0, 32'h0);
    lookup(32'h5003_1234, "R5 w3 disabled");
    @(negedge clk);
    cfg_we = 1'b1; cfg_win = 3'd3; cfg_sel = 2'd0;
    cfg_wdata = mk_ctrl(16'h000F, 8'h44, 4'd4, 1'b1);
    lk_addr = 32'h5003_1234;
    @(negedge clk);
    cfg_we = 1'b0;
    model(32'h5003_1234);
    cmp_lookup("R10 same-cycle old contents");
    m_reg[3][0] = mk_ctrl(16'h000F, 8'h44, 4'd4, 1'b1);
    @(negedge clk);
    model(32'h5003_1234);
    chk("R10 next-cycle hit", 64'(lk_hit), 64'd1);
    cmp_lookup("R10 next-cycle new contents");

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule